// File: doc/BRIEF.md
# Configurable FIFO with Retransmit Mark

A single-clock synchronous FIFO, 20 bits wide and 1024 words deep by default, whose operating mode and programmable flag thresholds are fixed while master reset is held. It works in one of two modes. In standard mode a read request loads the output register. In first-word-fall-through mode the oldest word is presented on its own, and a read request takes it. The two status outputs change meaning with the mode. In standard mode they are empty and full. In fall-through mode they are output-ready and input-ready.

A mark input saves the read position, and a retransmit input rewinds reads to it so that a stream can be replayed. While a mark is held, the entries from the mark onward still count as occupied, so that data can be replayed without being overwritten. A synchronous partial reset empties the queue and keeps the configuration. An output enable masks the data output to zero and leaves the flags untouched.

Top module: `rt_fifo`

## Requirements
- R1: While `rst_ni` is low, all pointers, the mark and the output register are zero. The standard flags read empty=1, full=0, alm_empty_no=0 and alm_full_no=1. `fwft_i` and `fsel_i` are sampled on every rising clock edge while `rst_ni` is low, and the last sample is kept. Changes to these inputs after release have no effect.
- R2: `fsel_i` picks the flag offset used as both n and m: 0 selects 7, 1 selects 31, 2 selects 63 and 3 selects 127.
- R3: In standard mode (`fwft_i`=0 at reset), `rd_en_i` with words stored places the oldest word on `rd_data_o` after that clock edge. A read when nothing is stored leaves `rd_data_o` unchanged. A write when all DEPTH entries are occupied is dropped.
- R4: In standard mode, `empty_ready_o` is 1 exactly when the stored count is 0, and `full_ready_o` is 1 exactly when the occupied count equals DEPTH. Both are registered and show a count one clock edge after the edge that changed it.
- R5: `alm_empty_no` is 1 when the stored count is at or above n and 0 below it. `alm_full_no` is 1 when the free count (DEPTH minus occupied) is above m and 0 at or below it. Both have the same one-edge lag as R4.
- R6: In fall-through mode (`fwft_i`=1), a word written into an empty FIFO appears on `rd_data_o`, and `empty_ready_o` rises, one edge after the write edge. Each `rd_en_i` edge consumes the word shown and presents the next. When no word is left, `empty_ready_o` falls. `full_ready_o` is the inverse of the full state, with the R4 lag. The array holds DEPTH words in addition to the one shown.
- R7: `mark_i` saves the current read pointer at the clock edge. A later mark replaces an earlier one.
- R8: `rexmit_i` sets the read pointer to the saved mark. In that cycle `rd_en_i` and `mark_i` are ignored, and in fall-through mode the shown word is dropped and fetched again. With no mark since the last reset, `rexmit_i` has no effect.
- R9: While a mark is held, every entry from the mark to the write pointer counts as occupied. A write is blocked once that span reaches DEPTH.
- R10: `prst_i` high at a clock edge clears the pointers, the mark, the output register and the flags, as in R1, and keeps the latched mode and offsets.
- R11: `oe_i` low forces `rd_data_o` to zero at once. No flag depends on `oe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| fwft_i | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| fsel_i | input | 2 | Flag offset select sampled during master reset |
| prst_i | input | 1 | Synchronous partial reset |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read enable |
| oe_i | input | 1 | Data output enable (1 = data shown) |
| mark_i | input | 1 | Save the read pointer |
| rexmit_i | input | 1 | Rewind the read pointer to the mark |
| rd_data_o | output | DW | Read data, zero while `oe_i` is low |
| empty_ready_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| full_ready_o | output | 1 | Full (standard) or input-ready (fall-through) |
| alm_empty_no | output | 1 | Low when the stored count is below n |
| alm_full_no | output | 1 | Low when the free count is at or below m |

## Verification
Read data in standard mode is due at the edge that takes the read. All count-derived flags are due one edge later. The bench therefore samples data at the falling edge right after a read, and idles one further cycle before it compares flags. In fall-through mode, a word written into an empty queue shows up one edge after its write edge, and the bench samples it at the falling edge after that second edge. The output-enable mask is combinational and is checked a nanosecond after `oe_i` changes, within the same cycle.

// File: rtl/rtf_pkg.sv
`timescale 1ns/1ps
package rtf_pkg;
  typedef struct packed {
    logic       fwft;
    logic [1:0] fsel;
  } rtf_cfg_t;

  // default threshold shared by both almost flags
  function automatic logic [7:0] rtf_offset(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd7;
      2'd1:    return 8'd31;
      2'd2:    return 8'd63;
      default: return 8'd127;
    endcase
  endfunction
endpackage

// File: rtl/rtf_cfg.sv
`timescale 1ns/1ps
module rtf_cfg
  import rtf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fwft_i,
  input  logic [1:0] fsel_i,
  output rtf_cfg_t   cfg_o
);
  // sampled only while master reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) cfg_o <= '{fwft: fwft_i, fsel: fsel_i};
  end
endmodule

// File: rtl/rtf_ptrs.sv
`timescale 1ns/1ps
module rtf_ptrs #(
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_i,
  input  logic          wr_en_i,
  input  logic          rd_req_i,
  input  logic          mark_i,
  input  logic          rexmit_i,
  output logic          do_wr_o,
  output logic          do_rd_o,
  output logic          rewind_o,
  output logic [CW-1:0] wptr_o,
  output logic [CW-1:0] rptr_o,
  output logic [CW-1:0] mark_ptr_o,
  output logic          mark_vld_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] occ_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] base;

  assign base     = mark_vld_o ? mark_ptr_o : rptr_o;
  assign cnt_o    = wptr_o - rptr_o;
  assign occ_o    = wptr_o - base;
  assign rewind_o = rexmit_i && mark_vld_o && !prst_i;
  assign do_wr_o  = wr_en_i && (occ_o < FULL_CNT) && !prst_i;
  assign do_rd_o  = rd_req_i && (cnt_o != '0) && !prst_i && !rewind_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o     <= '0;
      rptr_o     <= '0;
      mark_ptr_o <= '0;
      mark_vld_o <= 1'b0;
    end else if (prst_i) begin
      wptr_o     <= '0;
      rptr_o     <= '0;
      mark_ptr_o <= '0;
      mark_vld_o <= 1'b0;
    end else begin
      if (do_wr_o) wptr_o <= wptr_o + 1'b1;
      if (rewind_o) begin
        rptr_o <= mark_ptr_o;
      end else begin
        if (do_rd_o) rptr_o <= rptr_o + 1'b1;
        if (mark_i) begin
          mark_ptr_o <= rptr_o;
          mark_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtf_flags.sv
`timescale 1ns/1ps
module rtf_flags
  import rtf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_i,
  input  logic [1:0]    fsel_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] occ_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          ae_n_o,
  output logic          af_n_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] off, free;

  assign off  = CW'(rtf_offset(fsel_i));
  assign free = FULL_CNT - occ_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {empty_o, full_o, ae_n_o, af_n_o} <= 4'b1001;
    end else if (prst_i) begin
      {empty_o, full_o, ae_n_o, af_n_o} <= 4'b1001;
    end else begin
      empty_o <= (cnt_i == '0);
      full_o  <= (occ_i == FULL_CNT);
      ae_n_o  <= (cnt_i >= off);
      af_n_o  <= (free > off);
    end
  end
endmodule

// File: rtl/rt_fifo.sv
`timescale 1ns/1ps
module rt_fifo
  import rtf_pkg::*;
#(
  parameter int DW    = 20,
  parameter int DEPTH = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic [1:0]    fsel_i,
  input  logic          prst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          oe_i,
  input  logic          mark_i,
  input  logic          rexmit_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_ready_o,
  output logic          full_ready_o,
  output logic          alm_empty_no,
  output logic          alm_full_no
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  rtf_cfg_t      cfg_q;
  logic          cfg_fwft;
  logic          rd_req, do_wr, do_rd, rewind, mark_vld;
  logic [CW-1:0] wptr, rptr, mark_ptr, cnt, occ;
  logic          empty_q, full_q;
  logic [DW-1:0] dout_q;
  logic          ov_q;
  logic [DW-1:0] mem_q [DEPTH];

  assign cfg_fwft = cfg_q.fwft;

  rtf_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fwft_i (fwft_i),
    .fsel_i (fsel_i),
    .cfg_o  (cfg_q)
  );

  // fall-through refills the output register whenever it is free
  assign rd_req = cfg_fwft ? (!ov_q || rd_en_i) : rd_en_i;

  rtf_ptrs #(.DEPTH(DEPTH), .CW(CW)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prst_i     (prst_i),
    .wr_en_i    (wr_en_i),
    .rd_req_i   (rd_req),
    .mark_i     (mark_i),
    .rexmit_i   (rexmit_i),
    .do_wr_o    (do_wr),
    .do_rd_o    (do_rd),
    .rewind_o   (rewind),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .mark_ptr_o (mark_ptr),
    .mark_vld_o (mark_vld),
    .cnt_o      (cnt),
    .occ_o      (occ)
  );

  rtf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prst_i  (prst_i),
    .fsel_i  (cfg_q.fsel),
    .cnt_i   (cnt),
    .occ_i   (occ),
    .empty_o (empty_q),
    .full_o  (full_q),
    .ae_n_o  (alm_empty_no),
    .af_n_o  (alm_full_no)
  );

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      ov_q   <= 1'b0;
    end else if (prst_i) begin
      dout_q <= '0;
      ov_q   <= 1'b0;
    end else if (rewind) begin
      ov_q   <= 1'b0;
    end else if (do_rd) begin
      dout_q <= mem_q[rptr[AW-1:0]];
      ov_q   <= 1'b1;
    end else if (rd_en_i) begin
      ov_q   <= 1'b0;
    end
  end

  assign rd_data_o     = oe_i ? dout_q : '0;
  assign empty_ready_o = cfg_fwft ? ov_q : empty_q;
  assign full_ready_o  = cfg_fwft ? !full_q : full_q;
endmodule

// File: rtl/rt_fifo_chk.sv
`timescale 1ns/1ps
module rt_fifo_chk #(
  parameter int DW    = 20,
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prst_i,
  input logic          mark_i,
  input logic          rexmit_i,
  input logic          fwft,
  input logic [CW-1:0] wptr,
  input logic [CW-1:0] rptr,
  input logic [CW-1:0] mark_ptr,
  input logic          mark_vld,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] occ,
  input logic [DW-1:0] dout,
  input logic          empty_ready_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= FULL_CNT); // R9

  AST_NO_WRITE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == FULL_CNT && !prst_i) |=> $stable(wptr)); // R9

  AST_NO_READ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !prst_i && !(rexmit_i && mark_vld)) |=> $stable(rptr)); // R3

  AST_MARK_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !prst_i && !(rexmit_i && mark_vld)) |=> (mark_vld && mark_ptr == $past(rptr))); // R7

  AST_REXMIT_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rexmit_i && mark_vld && !prst_i) |=> (rptr == $past(mark_ptr))); // R8

  AST_PRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |=> (wptr == '0 && rptr == '0 && !mark_vld && dout == '0)); // R10

  AST_EMPTY_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && !prst_i) |=> (empty_ready_o == $past(cnt == '0))); // R4
endmodule

bind rt_fifo rt_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .prst_i        (prst_i),
  .mark_i        (mark_i),
  .rexmit_i      (rexmit_i),
  .fwft          (cfg_fwft),
  .wptr          (wptr),
  .rptr          (rptr),
  .mark_ptr      (mark_ptr),
  .mark_vld      (mark_vld),
  .cnt           (cnt),
  .occ           (occ),
  .dout          (dout_q),
  .empty_ready_o (empty_ready_o)
);

// File: tb/rt_fifo_tb.sv
`timescale 1ns/1ps
module rt_fifo_tb;
  localparam int DW    = 20;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rst_ni, fwft, prst, wr_en, rd_en, oe, mark, rexmit;
  logic [1:0]    fsel;
  logic [DW-1:0] wr_data, rd_data;
  logic          er, fr, aen, afn;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  rt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fwft_i(fwft), .fsel_i(fsel), .prst_i(prst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .oe_i(oe),
    .mark_i(mark), .rexmit_i(rexmit), .rd_data_o(rd_data),
    .empty_ready_o(er), .full_ready_o(fr), .alm_empty_no(aen), .alm_full_no(afn)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 7919 + 3) % (1 << DW));
  endfunction

  function automatic int offs(input logic [1:0] s);
    case (s)
      2'd0: return 7;
      2'd1: return 31;
      2'd2: return 63;
      default: return 127;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd1();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_mark();
    mark = 1'b1; @(negedge clk); mark = 1'b0;
  endtask

  task automatic pulse_rx();
    rexmit = 1'b1; @(negedge clk); rexmit = 1'b0;
  endtask

  task automatic pulse_prst();
    prst = 1'b1; @(negedge clk); prst = 1'b0;
  endtask

  task automatic mreset(input logic f, input logic [1:0] s);
    rst_ni = 1'b0; fwft = f; fsel = s;
    wr_en = 0; rd_en = 0; mark = 0; rexmit = 0; prst = 0; oe = 1;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    fwft = ~f; fsel = ~s;  // must be ignored after release (R1)
  endtask

  task automatic flags_std(input int k, input int n);
    chk("R4 empty", er, (k == 0));
    chk("R4 full", fr, (k == DEPTH));
    chk("R5 almost-empty", aen, (k >= n));
    chk("R5 almost-full", afn, ((DEPTH - k) > n));
  endtask

  task automatic sweep_std(input logic [1:0] fs);
    int n = offs(fs);  // R2
    mreset(1'b0, fs);
    chk("R1 data", rd_data, 0);
    flags_std(0, n);
    for (int k = 1; k <= DEPTH; k++) begin
      wr1(pat(k)); idle(1); flags_std(k, n);
    end
    wr1({DW{1'b1}}); idle(1);
    chk("R3 full holds", fr, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      rd1(); chk("R3 data", rd_data, pat(k));
      idle(1); flags_std(DEPTH - k, n);
    end
    rd1(); chk("R3 read when empty", rd_data, pat(DEPTH));
  endtask

  initial begin
    rst_ni = 1'b0; fwft = 0; fsel = 0; prst = 0; wr_en = 0; rd_en = 0;
    oe = 1; mark = 0; rexmit = 0; wr_data = '0;
    @(negedge clk);

    for (int s = 0; s < 4; s++) sweep_std(2'(s));

    // fall-through mode, offset 31
    mreset(1'b1, 2'd1);
    chk("R1 fwft ready", er, 0);
    chk("R1 fwft in-ready", fr, 1);
    chk("R1 fwft data", rd_data, 0);
    wr1(pat(0));
    chk("R6 not yet shown", er, 0);
    idle(1);
    chk("R6 shown", er, 1);
    chk("R6 first word", rd_data, pat(0));
    for (int i = 1; i <= DEPTH; i++) wr1(pat(i));
    idle(1);
    chk("R6 in-ready low", fr, 0);
    chk("R5 fwft almost-full", afn, 0);
    wr1({DW{1'b1}}); idle(1);
    rd_en = 1'b1;
    for (int i = 1; i <= DEPTH; i++) begin
      @(negedge clk);
      chk("R6 stream data", rd_data, pat(i));
      chk("R6 ready held", er, 1);
    end
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 ready drops", er, 0);
    idle(1);
    chk("R6 in-ready back", fr, 1);

    // partial reset keeps fall-through mode
    wr1(pat(5)); idle(1);
    chk("R6 refill", rd_data, pat(5));
    wr1(pat(6));
    pulse_prst();
    chk("R10 data cleared", rd_data, 0);
    chk("R10 ready cleared", er, 0);
    chk("R10 in-ready", fr, 1);
    wr1(pat(7));
    chk("R10 mode kept, not yet", er, 0);
    idle(1);
    chk("R10 mode kept", rd_data, pat(7));
    oe = 1'b0; #1;
    chk("R11 masked", rd_data, 0);
    chk("R11 flag kept", er, 1);
    oe = 1'b1; #1;
    chk("R11 unmasked", rd_data, pat(7));

    // retransmit, standard mode, offset 7
    mreset(1'b0, 2'd0);
    chk("R1 back to standard", er, 1);
    wr1(pat(100)); wr1(pat(101));
    rd1(); chk("R3 data", rd_data, pat(100));
    pulse_rx();
    rd1(); chk("R8 no mark ignored", rd_data, pat(101));
    pulse_prst();
    chk("R10 data", rd_data, 0);
    chk("R10 empty", er, 1);
    for (int i = 0; i < 10; i++) wr1(pat(i));
    rd1(); chk("R3 data", rd_data, pat(0));
    pulse_mark();
    rd1(); chk("R3 data", rd_data, pat(1));
    rd1(); chk("R3 data", rd_data, pat(2));
    pulse_mark();  // replaces the earlier mark (R7)
    for (int i = 3; i < 7; i++) begin
      rd1(); chk("R3 data", rd_data, pat(i));
    end
    idle(1);
    chk("R5 almost-empty after reads", aen, 0);
    chk("R9 free above m", afn, 1);
    for (int j = 0; j < DEPTH - 7; j++) wr1(pat(200 + j));
    idle(1);
    chk("R9 full with mark", fr, 1);
    chk("R9 almost-full", afn, 0);
    wr1({DW{1'b1}});
    pulse_rx();
    idle(1);
    chk("R8 count restored", aen, 1);
    for (int i = 3; i < 10; i++) begin
      rd1(); chk("R7 replay from latest mark", rd_data, pat(i));
    end
    for (int j = 0; j < DEPTH - 7; j++) begin
      rd1(); chk("R9 protected data", rd_data, pat(200 + j));
    end
    idle(1);
    chk("R8 empty after replay", er, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule